// File: doc/BRIEF.md
# Dual-Plane Protected Write Controller

This block stands between a byte-wide request port and an 8K-byte nonvolatile array. The array is treated as two independent 4K planes, and the top address bit picks the plane. Each plane has its own write engine. A write opens a load window that gathers bytes of one 32-byte page into a buffer for that plane. When the window closes, a programming phase of fixed length starts and copies the buffered bytes into the array through that plane's own write lane. While one plane is loading or programming, reads from the other plane are served from the array as normal. A read from the busy plane returns a polling byte instead, and one bit of that byte inverts on every such read.

Writes are gated by an 8-bit protection mask. There is one bit for each 1K section, and address bits [12:10] select the section. The mask is cleared only by the power-on reset and survives the synchronous soft reset. An external hold input keeps a load window open for as long as it is asserted, so the programming phase cannot start until the hold is released.

Requests use a valid/ready handshake. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` falls only while a read response is waiting for a consumer that holds `rsp_ready` low. Reads are answered one cycle after acceptance on `rsp_valid`/`rsp_data`. A response stays valid and unchanged until it is taken. The array read is asynchronous: `arr_rdata` must reflect `arr_raddr` within the same cycle. `PROG_CYCLES` must be at least the page size.

Top module: `plane_write_ctrl`

## Requirements
- R1: Address bit 12 selects the plane, and the two planes load and program independently. Plane p writes the array only on lane p (`arr_we[p]`, `arr_waddr[12p+11:12p]` holding address bits [11:0], `arr_wdata[8p+7:8p]`).
- R2: A read accepted for a plane in the idle state returns `arr_rdata` for that address on `rsp_data`, with `rsp_valid` high in the next cycle. This holds even while the other plane is loading or programming.
- R3: Section s is address bits [12:10]. A write to a section whose mask bit s is 0 is discarded, leaves the plane's state unchanged, and starts no cycle.
- R4: The protection mask reads 8'hFF after power-on reset and is loaded from `prot_wdata` on each cycle with `prot_we` high. The soft reset does not change it.
- R5: `soft_rst` returns both planes to idle, drops buffered bytes, and clears `rsp_valid`.
- R6: An enabled write to an idle plane opens a load for its 32-byte page (address bits [11:5]). Further writes to that page restart the window. A later write to the same byte replaces the earlier one. A single write is programmed as a page of one byte.
- R7: A load closes after `LOAD_WIN` consecutive cycles with no new byte while `wc_hold` is low. While `wc_hold` is high the window never expires.
- R8: An enabled write to a different page of a loading plane closes the load in that cycle and is itself discarded.
- R9: Programming lasts `PROG_CYCLES` cycles and writes only the buffered bytes, after which the plane is idle. Writes to a plane that is programming are discarded.
- R10: A read of a loading or programming plane returns 8'h00 or 8'h40. Bit 6 is 0 on the first such read after the load opens and inverts on each following such read. Once the plane is idle again, reads return array data.
- R11: `req_ready` = !`rsp_valid` || `rsp_ready`. While `rsp_valid` is high and `rsp_ready` is low, `rsp_valid` and `rsp_data` hold. After reset `rsp_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_rst_n | input | 1 | Power-on reset, active low, asynchronous |
| soft_rst | input | 1 | Synchronous soft reset; keeps the protection mask |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request ready |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 13 | Byte address |
| req_wdata | input | 8 | Write data |
| wc_hold | input | 1 | Holds an open load window |
| prot_we | input | 1 | Load protection mask |
| prot_wdata | input | 8 | New protection mask, bit s enables section s |
| rsp_valid | output | 1 | Read response valid |
| rsp_ready | input | 1 | Read response taken |
| rsp_data | output | 8 | Read data or polling byte |
| arr_raddr | output | 13 | Array read address |
| arr_rdata | input | 8 | Array read data (asynchronous) |
| arr_we | output | 2 | Array write enable per plane |
| arr_waddr | output | 24 | Array write offset per plane |
| arr_wdata | output | 16 | Array write data per plane |

## Verification
Two functions can meet in one cycle, and both cases are provoked on purpose. In the first, a read of one plane is accepted in the same cycle that a write opens or continues a load on the other plane. In the second, a write meant for a plane lands in the cycle that plane's window expires or while it is programming. The bench sets up both by issuing back-to-back requests to alternate planes and by timing a write a fixed number of cycles after a load opens. A behavioural model predicts, for every clock, `req_ready`, `rsp_valid` and `rsp_data`. Any disagreement, such as a polling byte in place of data or a late programming write, is reported at that cycle.

// File: rtl/pwc_pkg.sv
package pwc_pkg;
  typedef enum logic [1:0] {
    PL_IDLE = 2'd0,
    PL_LOAD = 2'd1,
    PL_PROG = 2'd2
  } pl_state_e;
endpackage

// File: rtl/pwc_prot_reg.sv
module pwc_prot_reg #(
  parameter int NUM_SECT = 8
) (
  input  logic                clk,
  input  logic                por_rst_n,
  input  logic                we,
  input  logic [NUM_SECT-1:0] wdata,
  output logic [NUM_SECT-1:0] mask
);
  // Only the power-on reset clears the mask; the soft reset is not wired here.
  always_ff @(posedge clk or negedge por_rst_n) begin
    if (!por_rst_n) mask <= '1;
    else if (we)    mask <= wdata;
  end
endmodule

// File: rtl/pwc_plane.sv
module pwc_plane
  import pwc_pkg::*;
#(
  parameter int OFF_W       = 12,
  parameter int DATA_W      = 8,
  parameter int PAGE_BYTES  = 32,
  parameter int LOAD_WIN    = 16,
  parameter int PROG_CYCLES = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_rst,
  input  logic              wr_hit,
  input  logic              rd_hit,
  input  logic              wc,
  input  logic [OFF_W-1:0]  off,
  input  logic [DATA_W-1:0] wdata,
  output pl_state_e         st_o,
  output logic              tog_o,
  output logic              arr_we,
  output logic [OFF_W-1:0]  arr_waddr,
  output logic [DATA_W-1:0] arr_wdata
);
  localparam int PG_W    = $clog2(PAGE_BYTES);
  localparam int PI_W    = OFF_W - PG_W;
  localparam int CNT_TOP = (LOAD_WIN > PROG_CYCLES) ? LOAD_WIN : PROG_CYCLES;
  localparam int CNT_W   = $clog2(CNT_TOP + 1);

  pl_state_e              st;
  logic [CNT_W-1:0]       cnt;
  logic [PI_W-1:0]        page_q;
  logic [PAGE_BYTES-1:0]  vld_q;
  logic [DATA_W-1:0]      pbuf_q [PAGE_BYTES];
  logic                   tog_q;

  logic [PG_W-1:0] lo;
  logic            same_page;
  logic            take;
  logic [PG_W-1:0] drain_idx;
  logic            in_drain;

  assign lo        = off[PG_W-1:0];
  assign same_page = (off[OFF_W-1:PG_W] == page_q);
  assign take      = wr_hit && ((st == PL_IDLE) || ((st == PL_LOAD) && same_page));
  assign drain_idx = cnt[PG_W-1:0];
  assign in_drain  = (st == PL_PROG) && (cnt < CNT_W'(PAGE_BYTES));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= PL_IDLE; cnt <= '0; page_q <= '0; vld_q <= '0; tog_q <= 1'b0;
    end else if (soft_rst) begin
      st <= PL_IDLE; cnt <= '0; page_q <= '0; vld_q <= '0; tog_q <= 1'b0;
    end else begin
      unique case (st)
        PL_IDLE: if (wr_hit) begin
          st     <= PL_LOAD;
          cnt    <= '0;
          page_q <= off[OFF_W-1:PG_W];
          vld_q  <= PAGE_BYTES'(1) << lo;
          tog_q  <= 1'b0;
        end
        PL_LOAD: begin
          if (wr_hit && same_page) begin
            vld_q[lo] <= 1'b1;
            cnt       <= '0;
          end else if (wr_hit) begin
            st  <= PL_PROG;
            cnt <= '0;
          end else if (wc) begin
            cnt <= '0;
          end else if (cnt == CNT_W'(LOAD_WIN - 1)) begin
            st  <= PL_PROG;
            cnt <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        PL_PROG: begin
          if (cnt == CNT_W'(PROG_CYCLES - 1)) begin
            st  <= PL_IDLE;
            cnt <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: st <= PL_IDLE;
      endcase
      if (rd_hit && (st != PL_IDLE)) tog_q <= ~tog_q;
    end
  end

  always_ff @(posedge clk) begin
    if (take) pbuf_q[lo] <= wdata;
  end

  assign arr_we    = in_drain && vld_q[drain_idx];
  assign arr_waddr = {page_q, drain_idx};
  assign arr_wdata = pbuf_q[drain_idx];
  assign st_o      = st;
  assign tog_o     = tog_q;

  // R7
  wc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n || soft_rst)
    (st == PL_LOAD && wc && !wr_hit) |=> (st == PL_LOAD));

  // R6
  load_open_chk: assert property (@(posedge clk) disable iff (!rst_n || soft_rst)
    $rose(st != PL_IDLE) |-> $past(wr_hit));

  // R9
  prog_exit_chk: assert property (@(posedge clk) disable iff (!rst_n || soft_rst)
    (st == PL_PROG) |=> (st != PL_LOAD));
endmodule

// File: rtl/pwc_rsp.sv
module pwc_rsp #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_rst,
  input  logic              load,
  input  logic [DATA_W-1:0] ld_data,
  input  logic              rsp_ready,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0; rsp_data <= '0;
    end else if (soft_rst) begin
      rsp_valid <= 1'b0; rsp_data <= '0;
    end else if (load) begin
      rsp_valid <= 1'b1; rsp_data <= ld_data;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  // R11
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n || soft_rst)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data)));
endmodule

// File: rtl/plane_write_ctrl.sv
module plane_write_ctrl
  import pwc_pkg::*;
#(
  parameter int ADDR_W      = 13,
  parameter int DATA_W      = 8,
  parameter int NUM_SECT    = 8,
  parameter int PAGE_BYTES  = 32,
  parameter int LOAD_WIN    = 16,
  parameter int PROG_CYCLES = 64
) (
  input  logic                       clk,
  input  logic                       por_rst_n,
  input  logic                       soft_rst,
  input  logic                       req_valid,
  output logic                       req_ready,
  input  logic                       req_write,
  input  logic [ADDR_W-1:0]          req_addr,
  input  logic [DATA_W-1:0]          req_wdata,
  input  logic                       wc_hold,
  input  logic                       prot_we,
  input  logic [NUM_SECT-1:0]        prot_wdata,
  output logic                       rsp_valid,
  input  logic                       rsp_ready,
  output logic [DATA_W-1:0]          rsp_data,
  output logic [ADDR_W-1:0]          arr_raddr,
  input  logic [DATA_W-1:0]          arr_rdata,
  output logic [1:0]                 arr_we,
  output logic [2*(ADDR_W-1)-1:0]    arr_waddr,
  output logic [2*DATA_W-1:0]        arr_wdata
);
  localparam int NUM_PLANES = 2;
  localparam int OFF_W      = ADDR_W - 1;
  localparam int SECT_W     = $clog2(NUM_SECT);
  localparam int TOG_BIT    = 6;

  logic              acc;
  logic              sel;
  logic [SECT_W-1:0] sect;
  logic [NUM_SECT-1:0] prot_q;
  pl_state_e         pl_st [NUM_PLANES];
  logic [NUM_PLANES-1:0] pl_tog;
  logic [NUM_PLANES-1:0] wr_hit;
  logic [NUM_PLANES-1:0] rd_hit;
  logic [DATA_W-1:0] stat_byte;
  logic [DATA_W-1:0] rd_byte;

  assign acc       = req_valid && req_ready;
  assign sel       = req_addr[ADDR_W-1];
  assign sect      = req_addr[ADDR_W-1 -: SECT_W];
  assign arr_raddr = req_addr;

  pwc_prot_reg #(.NUM_SECT(NUM_SECT)) u_prot (
    .clk(clk), .por_rst_n(por_rst_n), .we(prot_we), .wdata(prot_wdata), .mask(prot_q)
  );

  for (genvar p = 0; p < NUM_PLANES; p++) begin : g_plane
    assign wr_hit[p] = acc && req_write && (sel == 1'(p)) && prot_q[sect];
    assign rd_hit[p] = acc && !req_write && (sel == 1'(p));

    pwc_plane #(
      .OFF_W(OFF_W), .DATA_W(DATA_W), .PAGE_BYTES(PAGE_BYTES),
      .LOAD_WIN(LOAD_WIN), .PROG_CYCLES(PROG_CYCLES)
    ) u_plane (
      .clk(clk), .rst_n(por_rst_n), .soft_rst(soft_rst),
      .wr_hit(wr_hit[p]), .rd_hit(rd_hit[p]), .wc(wc_hold),
      .off(req_addr[OFF_W-1:0]), .wdata(req_wdata),
      .st_o(pl_st[p]), .tog_o(pl_tog[p]),
      .arr_we(arr_we[p]),
      .arr_waddr(arr_waddr[p*OFF_W +: OFF_W]),
      .arr_wdata(arr_wdata[p*DATA_W +: DATA_W])
    );

    // R2
    idle_read_chk: assert property (@(posedge clk) disable iff (!por_rst_n || soft_rst)
      (rd_hit[p] && pl_st[p] == PL_IDLE) |=> (rsp_valid && rsp_data == $past(arr_rdata)));

    // R3
    prot_gate_chk: assert property (@(posedge clk) disable iff (!por_rst_n || soft_rst)
      (acc && req_write && sel == 1'(p) && !prot_q[sect] && pl_st[p] == PL_IDLE)
        |=> (pl_st[p] == PL_IDLE));

    // R10
    poll_byte_chk: assert property (@(posedge clk) disable iff (!por_rst_n || soft_rst)
      (rd_hit[p] && pl_st[p] != PL_IDLE)
        |=> (rsp_data[TOG_BIT] == $past(pl_tog[p]) && $countones(rsp_data) <= 1));
  end

  always_comb begin
    stat_byte          = '0;
    stat_byte[TOG_BIT] = pl_tog[sel];
    rd_byte            = (pl_st[sel] != PL_IDLE) ? stat_byte : arr_rdata;
  end

  pwc_rsp #(.DATA_W(DATA_W)) u_rsp (
    .clk(clk), .rst_n(por_rst_n), .soft_rst(soft_rst),
    .load(acc && !req_write), .ld_data(rd_byte), .rsp_ready(rsp_ready),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data)
  );

  assign req_ready = !rsp_valid || rsp_ready;

  // R4
  prot_keep_chk: assert property (@(posedge clk) disable iff (!por_rst_n)
    (soft_rst && !prot_we) |=> $stable(prot_q));
endmodule

// File: tb/plane_write_ctrl_bench.sv
module plane_write_ctrl_bench;
  localparam int LW = 6;
  localparam int PC = 40;
  localparam int LIMIT = 200000;

  logic clk = 1'b0;
  logic por_rst_n = 1'b0, soft_rst = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [12:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic wc_hold = 1'b0, prot_we = 1'b0;
  logic [7:0] prot_wdata = '0;
  logic rsp_ready = 1'b1;
  logic req_ready, rsp_valid;
  logic [7:0] rsp_data;
  logic [12:0] arr_raddr;
  logic [7:0]  arr_rdata = '0;
  logic [1:0]  arr_we;
  logic [23:0] arr_waddr;
  logic [15:0] arr_wdata;

  int n_chk = 0, n_fail = 0;
  string cur = "R11";

  always #10 clk = ~clk;

  plane_write_ctrl #(.LOAD_WIN(LW), .PROG_CYCLES(PC)) u_plane_write_ctrl (
    .clk(clk), .por_rst_n(por_rst_n), .soft_rst(soft_rst),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .wc_hold(wc_hold),
    .prot_we(prot_we), .prot_wdata(prot_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .arr_raddr(arr_raddr), .arr_rdata(arr_rdata),
    .arr_we(arr_we), .arr_waddr(arr_waddr), .arr_wdata(arr_wdata)
  );

  function automatic logic [7:0] init_byte(int a);
    return 8'((a * 37) ^ (a >> 5) ^ 8'h5C);
  endfunction

  // array stand-in, sparse
  logic [7:0] mem [int];
  function automatic logic [7:0] mem_rd(int a);
    return mem.exists(a) ? mem[a] : init_byte(a);
  endfunction
  always @(posedge clk) begin
    for (int p = 0; p < 2; p++)
      if (arr_we[p]) mem[p * 4096 + int'(arr_waddr[p*12 +: 12])] = arr_wdata[p*8 +: 8];
  end
  always @(negedge clk) begin
    #1 arr_rdata = mem_rd(int'(arr_raddr));
  end

  // behavioural reference model
  logic [7:0] shadow [int];
  function automatic logic [7:0] sh_rd(int a);
    return shadow.exists(a) ? shadow[a] : init_byte(a);
  endfunction
  int   m_st [2];
  int   m_cnt [2];
  int   m_page [2];
  logic [7:0] m_buf [2][32];
  bit   m_vld [2][32];
  bit   m_tog [2];
  bit   m_rv;
  logic [7:0] m_rd;
  logic [7:0] m_prot;
  bit   m_ready;

  task automatic commit(int p);
    for (int i = 0; i < 32; i++)
      if (m_vld[p][i]) shadow[p * 4096 + m_page[p] * 32 + i] = m_buf[p][i];
  endtask

  always @(posedge clk) begin
    bit acc, hit;
    int sel, sec, lo, pg;
    if (!por_rst_n) begin
      m_prot = 8'hFF; m_rv = 0; m_rd = 0;
      for (int p = 0; p < 2; p++) begin
        m_st[p] = 0; m_cnt[p] = 0; m_tog[p] = 0;
        for (int i = 0; i < 32; i++) m_vld[p][i] = 0;
      end
    end else begin
      if (soft_rst) begin
        m_rv = 0; m_rd = 0;
        for (int p = 0; p < 2; p++) begin
          m_st[p] = 0; m_cnt[p] = 0; m_tog[p] = 0;
          for (int i = 0; i < 32; i++) m_vld[p][i] = 0;
        end
      end else begin
        acc = req_valid && (!m_rv || rsp_ready);
        sel = int'(req_addr[12]);
        sec = int'(req_addr[12:10]);
        lo  = int'(req_addr[4:0]);
        pg  = int'(req_addr[11:5]);
        if (acc && !req_write) begin
          m_rv = 1;
          if (m_st[sel] != 0) begin
            m_rd = m_tog[sel] ? 8'h40 : 8'h00;
            m_tog[sel] = !m_tog[sel];
          end else m_rd = sh_rd(int'(req_addr));
        end else if (rsp_ready) m_rv = 0;
        for (int p = 0; p < 2; p++) begin
          hit = acc && req_write && sel == p && m_prot[sec];
          case (m_st[p])
            0: if (hit) begin
              m_st[p] = 1; m_cnt[p] = 0; m_page[p] = pg; m_tog[p] = 0;
              for (int i = 0; i < 32; i++) m_vld[p][i] = 0;
              m_vld[p][lo] = 1; m_buf[p][lo] = req_wdata;
            end
            1: if (hit && pg == m_page[p]) begin
              m_vld[p][lo] = 1; m_buf[p][lo] = req_wdata; m_cnt[p] = 0;
            end else if (hit) begin
              m_st[p] = 2; m_cnt[p] = 0; commit(p);
            end else if (wc_hold) m_cnt[p] = 0;
            else if (m_cnt[p] == LW - 1) begin
              m_st[p] = 2; m_cnt[p] = 0; commit(p);
            end else m_cnt[p]++;
            default: if (m_cnt[p] == PC - 1) begin
              m_st[p] = 0; m_cnt[p] = 0;
            end else m_cnt[p]++;
          endcase
        end
      end
      if (prot_we) m_prot = prot_wdata;
    end
  end

  // per-clock comparison, well clear of both edges
  always @(posedge clk) begin
    #4;
    if (por_rst_n) begin
      m_ready = !m_rv || rsp_ready;
      n_chk++;
      if (rsp_valid !== m_rv || req_ready !== m_ready || (m_rv && rsp_data !== m_rd)) begin
        n_fail++;
        $display("FAIL %s clock compare: valid=%0b ready=%0b data=%h, expected valid=%0b ready=%0b data=%h",
                 cur, rsp_valid, req_ready, rsp_data, m_rv, m_ready, m_rd);
      end
    end
  end

  task automatic ck(bit ok, string tag, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [12:0] a, logic [7:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
  endtask

  task automatic idle();
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic rd(logic [12:0] a, output logic [7:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
    d = rsp_data;
  endtask

  task automatic wait_c(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(LIMIT * 20);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [7:0] d, d2;
    repeat (3) @(negedge clk);
    por_rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    ck(rsp_valid == 1'b0, "R11 reset valid", rsp_valid, 0);
    ck(req_ready == 1'b1, "R11 reset ready", req_ready, 1);

    cur = "R2";
    rd(13'h0003, d); ck(d == init_byte(3), "R2 plane0 read", d, init_byte(3));
    rd(13'h1234, d); ck(d == init_byte('h1234), "R2 plane1 read", d, init_byte('h1234));

    cur = "R6";
    wr(13'h0010, 8'hA5); idle(); wait_c(LW + PC + 4);
    rd(13'h0010, d); ck(d == 8'hA5, "R6 single byte", d, 8'hA5);

    wr(13'h0020, 8'h11); wr(13'h0021, 8'h22); wr(13'h0022, 8'h33); wr(13'h0021, 8'h44); idle();
    cur = "R10";
    rd(13'h0020, d);  ck(d == 8'h00, "R10 first poll", d, 8'h00);
    rd(13'h0020, d2); ck(d2 == 8'h40, "R10 second poll", d2, 8'h40);
    cur = "R2";
    rd(13'h1100, d); ck(d == init_byte('h1100), "R2 other plane during write", d, init_byte('h1100));
    wait_c(LW + PC + 4);
    cur = "R6";
    rd(13'h0021, d); ck(d == 8'h44, "R6 last write wins", d, 8'h44);
    rd(13'h0022, d); ck(d == 8'h33, "R6 page byte", d, 8'h33);
    rd(13'h0023, d); ck(d == init_byte('h23), "R6 untouched byte", d, init_byte('h23));
    cur = "R10";
    rd(13'h0020, d); ck(d == 8'h11, "R10 data after idle", d, 8'h11);

    cur = "R8";
    wr(13'h0040, 8'h5A); wr(13'h0060, 8'h6B); idle();
    rd(13'h0040, d); ck(d == 8'h00, "R8 busy after page change", d, 8'h00);
    wait_c(LW + PC + 4);
    rd(13'h0040, d); ck(d == 8'h5A, "R8 first page kept", d, 8'h5A);
    rd(13'h0060, d); ck(d == init_byte('h60), "R8 other page discarded", d, init_byte('h60));

    cur = "R7";
    @(negedge clk) wc_hold = 1'b1;
    wr(13'h0080, 8'h77); idle(); wait_c(4 * LW + PC);
    rd(13'h0080, d); ck(d == 8'h00, "R7 held load still busy", d, 8'h00);
    @(negedge clk) wc_hold = 1'b0;
    wait_c(LW + PC + 4);
    rd(13'h0080, d); ck(d == 8'h77, "R7 programmed after release", d, 8'h77);

    cur = "R1";
    wr(13'h00C0, 8'hC1); wr(13'h10C0, 8'hD1); idle();
    rd(13'h00C0, d);  ck(d == 8'h00, "R1 plane0 busy", d, 8'h00);
    rd(13'h10C0, d);  ck(d == 8'h00, "R1 plane1 busy", d, 8'h00);
    wait_c(LW + PC + 4);
    rd(13'h00C0, d);  ck(d == 8'hC1, "R1 plane0 data", d, 8'hC1);
    rd(13'h10C0, d);  ck(d == 8'hD1, "R1 plane1 data", d, 8'hD1);

    cur = "R9";
    wr(13'h00A0, 8'hE1); idle(); wait_c(LW + 3);
    wr(13'h00A1, 8'hE2); idle(); wait_c(PC + 4);
    rd(13'h00A1, d); ck(d == init_byte('hA1), "R9 write while programming dropped", d, init_byte('hA1));
    rd(13'h00A0, d); ck(d == 8'hE1, "R9 programmed byte", d, 8'hE1);

    cur = "R3";
    @(negedge clk); prot_we = 1'b1; prot_wdata = 8'hFE;
    @(negedge clk); prot_we = 1'b0;
    wr(13'h0005, 8'h99); idle();
    rd(13'h0005, d); ck(d == init_byte(5), "R3 locked section stays idle", d, init_byte(5));
    wr(13'h0405, 8'h98); idle();
    rd(13'h0405, d); ck(d == 8'h00, "R3 open section busy", d, 8'h00);
    wait_c(LW + PC + 4);
    rd(13'h0405, d); ck(d == 8'h98, "R3 open section written", d, 8'h98);

    cur = "R5";
    wr(13'h0800, 8'h55); idle();
    @(negedge clk) soft_rst = 1'b1;
    @(negedge clk) soft_rst = 1'b0;
    rd(13'h0800, d); ck(d == init_byte('h800), "R5 idle after soft reset", d, init_byte('h800));
    wait_c(LW + PC + 4);
    rd(13'h0800, d); ck(d == init_byte('h800), "R5 buffer dropped", d, init_byte('h800));
    cur = "R4";
    wr(13'h0005, 8'h97); idle(); wait_c(LW + PC + 4);
    rd(13'h0005, d); ck(d == init_byte(5), "R4 mask kept over soft reset", d, init_byte(5));
    @(negedge clk) por_rst_n = 1'b0;
    @(negedge clk) por_rst_n = 1'b1;
    wr(13'h0005, 8'h96); idle(); wait_c(LW + PC + 4);
    rd(13'h0005, d); ck(d == 8'h96, "R4 mask reopened by power-on reset", d, 8'h96);

    cur = "R11";
    @(negedge clk); rsp_ready = 1'b0; req_valid = 1'b1; req_write = 1'b0; req_addr = 13'h0007;
    @(negedge clk); req_valid = 1'b1; req_write = 1'b1; req_addr = 13'h0009; req_wdata = 8'h12;
    wait_c(3);
    ck(rsp_valid == 1'b1, "R11 response held", rsp_valid, 1);
    ck(rsp_data == init_byte(7), "R11 data held", rsp_data, init_byte(7));
    ck(req_ready == 1'b0, "R11 ready low under back-pressure", req_ready, 0);
    req_valid = 1'b0;
    @(negedge clk) rsp_ready = 1'b1;
    @(negedge clk);
    ck(rsp_valid == 1'b0, "R11 response taken", rsp_valid, 0);
    rd(13'h0009, d); ck(d == init_byte(9), "R11 stalled write not taken", d, init_byte(9));

    wait_c(2);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule